// File: doc/BRIEF.md
# Indexed Code Table Lookup Unit

This unit performs a single byte lookup from program memory on behalf of an execution pipeline. The caller presents an 8-bit accumulator, a 16-bit data pointer, the 24-bit program counter and the current status word, and pulses a start strobe. The unit then forms a code address in one of two ways. In pointer-indexed form, the accumulator is added to the data pointer, the 16-bit result replaces the low half of the address, and the page bits are taken from the top of the program counter. In counter-relative form, the accumulator is added to the full program counter.

The unit drives one read cycle on a code memory port that returns data one cycle after the address. It then returns the byte as the new accumulator value, together with a status word in which only the zero and negative flags are recomputed. A one-cycle done pulse marks the new results. The results hold until the next lookup completes. Instruction fetch and decode belong to the surrounding core.

Top module: `codeTableFetch`

## Requirements
- R1: With mode = 0 (pointer-indexed), the read address is {pcIn[23:16], (accIn + ptrIn) mod 2^16}. A carry out of the 16-bit sum never reaches bit 16.
- R2: With mode = 1 (counter-relative), the read address is (pcIn + zero-extended accIn) mod 2^24.
- R3: When done is high, accOut equals the byte that code memory returned for the issued address.
- R4: When done is high, pswOut bit 1 (zero flag) is 1 if the fetched byte is 0x00 and 0 otherwise.
- R5: When done is high, pswOut bit 2 (negative flag) equals bit 7 of the fetched byte.
- R6: When done is high, every pswOut bit other than bits 1 and 2 equals the pswIn value sampled with the accepted start.
- R7: memRdEn is high for exactly one cycle, the cycle after the clock edge that accepts start. Done is high for exactly one cycle, two cycles after memRdEn.
- R8: A start that arrives while a lookup is in progress is ignored: it causes no extra read and no extra done pulse. Between done pulses, accOut and pswOut hold their values.
- R9: While reset is held (rstN low), memRdEn, done, accOut and pswOut are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a lookup (accepted when idle) |
| mode | input | 1 | 0 = pointer-indexed, 1 = counter-relative |
| accIn | input | 8 | Accumulator value |
| ptrIn | input | 16 | Data pointer value |
| pcIn | input | 24 | Current program counter |
| pswIn | input | 8 | Current status word |
| memRdEn | output | 1 | Code memory read enable |
| memAddr | output | 24 | Code memory read address |
| memRdData | input | 8 | Code memory read data (one-cycle latency) |
| accOut | output | 8 | New accumulator value |
| pswOut | output | 8 | New status word |
| done | output | 1 | Result valid pulse |

## Verification
The bench builds the unit with its default sizes: a 24-bit counter, a 16-bit pointer, an 8-bit accumulator, and the flag bits at positions 1 and 2. At these sizes, small accumulator values are enough to cross the 16-bit page boundary in pointer mode and the 24-bit wrap in counter mode. The byte-wide code memory model returns zero bytes and bytes with bit 7 set at addresses that are easy to reach. The bench also pokes start while the unit is busy and changes the status word in the middle of a lookup, to show that the status word is sampled once and that extra requests are dropped.

// File: rtl/codeTablePkg.sv
package codeTablePkg;

  typedef enum logic {
    MODE_PTR = 1'b0,
    MODE_PC  = 1'b1
  } lookupMode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_CAPT  = 2'd2
  } fetchState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;      // latch address and status word
    logic captureData;  // latch fetched byte and merged flags
  } ctrlStrobes_t;

endpackage

// File: rtl/codeTableCtrl.sv
module codeTableCtrl
  import codeTablePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrlStrobes_t strobes,
  output logic         memRdEn,
  output logic         done
);

  fetchState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.loadReq = 1'b1;
          stateNext       = ST_ISSUE;
        end
      end
      ST_ISSUE: stateNext = ST_CAPT;
      ST_CAPT: begin
        strobes.captureData = 1'b1;
        stateNext           = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobes.captureData;
    end
  end

  assign memRdEn = (state == ST_ISSUE);

endmodule

// File: rtl/codeTableDatapath.sv
module codeTableDatapath
  import codeTablePkg::*;
#(
  parameter int PC_W  = 24,
  parameter int PTR_W = 16,
  parameter int ACC_W = 8,
  parameter int PSW_W = 8,
  parameter int Z_POS = 1,
  parameter int N_POS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic             mode,
  input  logic [ACC_W-1:0] accIn,
  input  logic [PTR_W-1:0] ptrIn,
  input  logic [PC_W-1:0]  pcIn,
  input  logic [PSW_W-1:0] pswIn,
  input  logic [ACC_W-1:0] memRdData,
  output logic [PC_W-1:0]  memAddr,
  output logic [ACC_W-1:0] accOut,
  output logic [PSW_W-1:0] pswOut
);

  localparam int PAGE_W = PC_W - PTR_W;

  logic [PTR_W-1:0] ptrSum;
  logic [PC_W-1:0]  ptrAddr;
  logic [PC_W-1:0]  pcAddr;
  logic [PC_W-1:0]  addrNext;
  logic [PSW_W-1:0] pswHold;
  logic [PSW_W-1:0] pswMerged;

  // pointer sum wraps inside the page
  assign ptrSum = ptrIn + PTR_W'(accIn);

  generate
    if (PAGE_W > 0) begin : g_paged
      assign ptrAddr = {pcIn[PC_W-1:PTR_W], ptrSum};
    end else begin : g_flat
      assign ptrAddr = PC_W'(ptrSum);
    end
  endgenerate

  assign pcAddr   = pcIn + PC_W'(accIn);
  assign addrNext = (mode == MODE_PC) ? pcAddr : ptrAddr;

  always_comb begin
    pswMerged        = pswHold;
    pswMerged[Z_POS] = (memRdData == '0);
    pswMerged[N_POS] = memRdData[ACC_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr <= '0;
      pswHold <= '0;
      accOut  <= '0;
      pswOut  <= '0;
    end else begin
      if (strobes.loadReq) begin
        memAddr <= addrNext;
        pswHold <= pswIn;
      end
      if (strobes.captureData) begin
        accOut <= memRdData;
        pswOut <= pswMerged;
      end
    end
  end

endmodule

// File: rtl/codeTableFetch.sv
module codeTableFetch
  import codeTablePkg::*;
#(
  parameter int PC_W  = 24,
  parameter int PTR_W = 16,
  parameter int ACC_W = 8,
  parameter int PSW_W = 8,
  parameter int Z_POS = 1,
  parameter int N_POS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             mode,
  input  logic [ACC_W-1:0] accIn,
  input  logic [PTR_W-1:0] ptrIn,
  input  logic [PC_W-1:0]  pcIn,
  input  logic [PSW_W-1:0] pswIn,
  output logic             memRdEn,
  output logic [PC_W-1:0]  memAddr,
  input  logic [ACC_W-1:0] memRdData,
  output logic [ACC_W-1:0] accOut,
  output logic [PSW_W-1:0] pswOut,
  output logic             done
);

  ctrlStrobes_t strobes;

  codeTableCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .memRdEn (memRdEn),
    .done    (done)
  );

  codeTableDatapath #(
    .PC_W  (PC_W),
    .PTR_W (PTR_W),
    .ACC_W (ACC_W),
    .PSW_W (PSW_W),
    .Z_POS (Z_POS),
    .N_POS (N_POS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .mode      (mode),
    .accIn     (accIn),
    .ptrIn     (ptrIn),
    .pcIn      (pcIn),
    .pswIn     (pswIn),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .accOut    (accOut),
    .pswOut    (pswOut)
  );

endmodule

// File: rtl/codeTableFetchChk.sv
module codeTableFetchChk #(
  parameter int PC_W  = 24,
  parameter int PTR_W = 16,
  parameter int ACC_W = 8,
  parameter int PSW_W = 8,
  parameter int Z_POS = 1,
  parameter int N_POS = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             mode,
  input logic [ACC_W-1:0] accIn,
  input logic [PTR_W-1:0] ptrIn,
  input logic [PC_W-1:0]  pcIn,
  input logic [PSW_W-1:0] pswIn,
  input logic             memRdEn,
  input logic [PC_W-1:0]  memAddr,
  input logic [ACC_W-1:0] accOut,
  input logic [PSW_W-1:0] pswOut,
  input logic             done
);

  localparam logic [PSW_W-1:0] FLAG_MASK = PSW_W'((1 << Z_POS) | (1 << N_POS));

  assert_ptr_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && !$past(mode)) |->
      (memAddr == {$past(pcIn[PC_W-1:PTR_W]), PTR_W'($past(ptrIn) + PTR_W'($past(accIn)))}));

  assert_pc_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && $past(mode)) |-> (memAddr == PC_W'($past(pcIn) + PC_W'($past(accIn)))));

  assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pswOut[Z_POS] == (accOut == '0)));

  assert_neg_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pswOut[N_POS] == accOut[ACC_W-1]));

  assert_psw_pass_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((pswOut & ~FLAG_MASK) == ($past(pswIn, 3) & ~FLAG_MASK)));

  assert_read_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  assert_read_after_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> $past(start));

  assert_done_spacing_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(memRdEn, 2));

  assert_hold_results_R8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(accOut) && $stable(pswOut)));

endmodule

bind codeTableFetch codeTableFetchChk #(
  .PC_W  (PC_W),
  .PTR_W (PTR_W),
  .ACC_W (ACC_W),
  .PSW_W (PSW_W),
  .Z_POS (Z_POS),
  .N_POS (N_POS)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .mode    (mode),
  .accIn   (accIn),
  .ptrIn   (ptrIn),
  .pcIn    (pcIn),
  .pswIn   (pswIn),
  .memRdEn (memRdEn),
  .memAddr (memAddr),
  .accOut  (accOut),
  .pswOut  (pswOut),
  .done    (done)
);

// File: tb/codeTableFetch_tb.sv
module codeTableFetch_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [7:0]  accIn = '0;
  logic [15:0] ptrIn = '0;
  logic [23:0] pcIn = '0;
  logic [7:0]  pswIn = '0;
  logic        memRdEn;
  logic [23:0] memAddr;
  logic [7:0]  memRdData = '0;
  logic [7:0]  accOut;
  logic [7:0]  pswOut;
  logic        done;

  always #5 clk = ~clk;

  codeTableFetch u_dut (
    .clk (clk), .rstN (rstN), .start (start), .mode (mode),
    .accIn (accIn), .ptrIn (ptrIn), .pcIn (pcIn), .pswIn (pswIn),
    .memRdEn (memRdEn), .memAddr (memAddr), .memRdData (memRdData),
    .accOut (accOut), .pswOut (pswOut), .done (done)
  );

  function automatic logic [7:0] romByte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16];
  endfunction

  // code memory model, one-cycle read latency
  always @(posedge clk) if (memRdEn) memRdData <= romByte(memAddr);

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastRdCyc = -100;
  int doneSeen = 0;
  int opsSent = 0;
  bit finished = 1'b0;
  logic prevRd = 1'b0;
  logic [7:0] lastAcc = '0;
  logic [7:0] lastPsw = '0;

  logic [23:0] addrQ[$];
  string       tagQ[$];
  logic [7:0]  accQ[$];
  logic [7:0]  pswQ[$];

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (memRdEn) begin
        check(!prevRd, "R7", "read enable longer than one cycle", 1, 0);
        if (addrQ.size() == 0) begin
          check(1'b0, "R8", "read without accepted start", memAddr, 0);
        end else begin
          logic [23:0] eAddr;
          string tag;
          eAddr = addrQ.pop_front();
          tag = tagQ.pop_front();
          check(memAddr == eAddr, tag, "read address", memAddr, eAddr);
        end
        lastRdCyc = cyc;
      end
      if (done) begin
        doneSeen++;
        check(cyc - lastRdCyc == 2, "R7", "done spacing after read", cyc - lastRdCyc, 2);
        if (accQ.size() == 0) begin
          check(1'b0, "R8", "done without pending lookup", 1, 0);
        end else begin
          logic [7:0] eAcc, ePsw;
          eAcc = accQ.pop_front();
          ePsw = pswQ.pop_front();
          check(accOut == eAcc, "R3", "accumulator", accOut, eAcc);
          check(pswOut[1] == ePsw[1], "R4", "zero flag", pswOut[1], ePsw[1]);
          check(pswOut[2] == ePsw[2], "R5", "negative flag", pswOut[2], ePsw[2]);
          check((pswOut & 8'hF9) == (ePsw & 8'hF9), "R6", "other status bits",
                pswOut & 8'hF9, ePsw & 8'hF9);
          lastAcc = eAcc;
          lastPsw = ePsw;
        end
      end
      prevRd = memRdEn;
    end
  end

  // driver: one lookup, optionally poking start while busy
  task automatic runOp(input bit m, input logic [7:0] a, input logic [15:0] p,
                       input logic [23:0] pc, input logic [7:0] psw, input bit poke);
    logic [23:0] eAddr;
    logic [7:0]  b;
    logic [7:0]  eP;
    logic [15:0] s;
    if (m) begin
      eAddr = pc + {16'h0, a};
      tagQ.push_back("R2");
    end else begin
      s = p + {8'h0, a};
      eAddr = {pc[23:16], s};
      tagQ.push_back("R1");
    end
    b = romByte(eAddr);
    eP = psw & 8'hF9;
    eP[1] = (b == 8'h00);
    eP[2] = b[7];
    addrQ.push_back(eAddr);
    accQ.push_back(b);
    pswQ.push_back(eP);
    opsSent++;
    @(negedge clk);
    mode = m; accIn = a; ptrIn = p; pcIn = pc; pswIn = psw; start = 1'b1;
    @(negedge clk);
    start = poke;
    if (poke) begin
      mode = ~m; accIn = ~a; ptrIn = ~p; pcIn = ~pc; pswIn = ~psw;
    end
    @(negedge clk);
    start = poke;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values
    check(memRdEn == 1'b0, "R9", "memRdEn in reset", memRdEn, 0);
    check(done == 1'b0, "R9", "done in reset", done, 0);
    check(accOut == 8'h00, "R9", "accOut in reset", accOut, 0);
    check(pswOut == 8'h00, "R9", "pswOut in reset", pswOut, 0);
    rstN = 1'b1;
    // R1: plain pointer sum inside page AB
    runOp(1'b0, 8'h10, 16'h1234, 24'hAB0000, 8'hFF, 1'b0);
    // R1: sum wraps at 16 bits, page stays 5A
    runOp(1'b0, 8'h01, 16'hFFFF, 24'h5A7777, 8'h00, 1'b0);
    // R4: byte 00 (page 33, low half 3300)
    runOp(1'b0, 8'h00, 16'h3300, 24'h33ABCD, 8'hA5, 1'b0);
    // R5: byte 85 has bit 7 set
    runOp(1'b0, 8'h05, 16'h0000, 24'h80FFFF, 8'h5A, 1'b0);
    // R2: counter-relative, carry into upper bytes
    runOp(1'b1, 8'hF0, 16'hBEEF, 24'h0101F0, 8'h3C, 1'b0);
    // R2: 24-bit wrap
    runOp(1'b1, 8'h20, 16'h0000, 24'hFFFFF0, 8'hC3, 1'b0);
    // R8 and R6: start poked while busy, inputs changed mid-lookup
    runOp(1'b0, 8'h44, 16'h2211, 24'h660000, 8'h81, 1'b1);
    runOp(1'b1, 8'h7F, 16'h0000, 24'h123456, 8'h7E, 1'b1);
    repeat (6) @(negedge clk);
    check(accOut == lastAcc, "R8", "accOut held while idle", accOut, lastAcc);
    check(pswOut == lastPsw, "R8", "pswOut held while idle", pswOut, lastPsw);
    check(doneSeen == opsSent, "R8", "done pulse count", doneSeen, opsSent);
    for (int i = 0; i < 24; i++) begin
      runOp(1'($urandom), 8'($urandom), 16'($urandom), 24'($urandom),
            8'($urandom), 1'($urandom));
    end
    repeat (6) @(negedge clk);
    check(doneSeen == opsSent, "R8", "final done pulse count", doneSeen, opsSent);
    check(addrQ.size() == 0, "R7", "reads outstanding", addrQ.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", doneSeen, opsSent);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule